// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks a bank of up to eight SDRAM rows through the start-up ritual they need before they can accept ordinary traffic. After a start strobe it waits for supplies and clocks to settle, then steps through a fixed list of commands: a no-operation, a precharge of all banks, eight auto-refresh (CBR) cycles, and a mode-register load. Each command goes to every populated row in turn before the next step begins. When the list is finished, the block returns the command mode to normal operation, raises its completion flag and enables periodic refresh.

Each command issue is a single-cycle strobe carrying the command mode, the index of the chip select to drive and, for the mode-register load, the address word that encodes the burst and latency settings. The mode address depends on the selected CAS latency. For the upper half of the rows it is also bit-flipped, because the board inverts part of the address bus there. Every delay is counted in clock cycles and set by a parameter, so a fast simulation build and a real timing build share the same logic.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `cmd_vld_o`, `done_o` and `refresh_en_o` are 0, `cmd_o` is 000 and `mode_addr_o` is 0.
- R2: `cmd_o` uses the encoding 000 normal, 001 NOP, 010 precharge-all, 011 mode-register set, 100 CBR refresh. No issue strobe ever carries 000 or a value from 101 to 111.
- R3: Steps are issued in the order NOP, precharge-all, exactly eight CBR refreshes, mode-register set.
- R4: Within one step, the command is issued once to each row whose bit in `row_pop_i` is 1, in ascending row order, on consecutive cycles. Unpopulated rows take no cycle and are never selected.
- R5: The first NOP issue happens `PWR_CYC` cycles after the clock edge that samples `start_i`.
- R6: After the last issue of a step, the first issue of the next step follows W+1 cycles later. W is `NOP_WAIT_CYC` after NOP, `TRP_CYC` after precharge, and `TRC_CYC` after each CBR.
- R7: During a mode-register issue, `mode_addr_o` is 0x1D0 for rows 0–3 and 0x1E28 for rows 4–7 when `cas2_i`=0 (latency 3). It is 0x150 and 0x1EA8 when `cas2_i`=1 (latency 2). At all other times it is 0.
- R8: `done_o` and `refresh_en_o` rise `MRS_WAIT_CYC`+1 cycles after the last mode-register issue, with `cmd_o` back at 000 and no further issues.
- R9: `done_o` and `refresh_en_o` stay high until the next start strobe, and are low on the cycle after that strobe is sampled.
- R10: A start strobe received while the sequence is running has no effect on the issued commands or their timing.
- R11: With `row_pop_i` all zero, the sequence still completes and raises `done_o` without a single issue strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, honoured only when idle or done |
| cas2_i | input | 1 | 1 selects CAS latency 2, 0 selects latency 3 |
| row_pop_i | input | ROWS | Per-row populated mask, bit r for row r |
| cmd_o | output | 3 | Current command mode |
| cmd_vld_o | output | 1 | One-cycle issue strobe for the command to row `cs_idx_o` |
| cs_idx_o | output | log2(ROWS) | Row (chip-select) index of the current issue |
| mode_addr_o | output | ADDR_W | Mode-register address word during a mode-register issue |
| refresh_en_o | output | 1 | Periodic refresh enabled |
| done_o | output | 1 | Initialization finished |

## Verification
On every cycle, the checker confirms four things: an issue never carries a normal or reserved mode, issues within a step target only populated rows in strictly rising order, the address word is zero outside mode-register issues, and the completion state is quiet and holds until a new start. The ordering of the steps, the exact power-up and inter-step gaps, the exact address values per row half and latency, the empty-mask case and the rejection of a mid-run start are shown only by the bench. It replays whole sequences over a sweep of masks and both latencies and compares each logged issue with an arithmetic model.

// File: rtl/sdram_init_pkg.sv
// Shared types for the SDRAM initialization sequencer.
// Assumes a 3-bit command mode field whose encoding is fixed by the memory controller.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        SD_CMD_NORMAL = 3'b000,
        SD_CMD_NOP    = 3'b001,
        SD_CMD_PREALL = 3'b010,
        SD_CMD_MRS    = 3'b011,
        SD_CMD_CBR    = 3'b100
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_NOP_ISS,
        ST_NOP_WT,
        ST_PRE_ISS,
        ST_PRE_WT,
        ST_CBR_ISS,
        ST_CBR_WT,
        ST_MRS_ISS,
        ST_MRS_WT,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/sdram_init_timer.sv
// Down-counting delay timer.
// Loading N-1 makes expired_o true on the N-th cycle after the load edge.
// Assumes the owner never loads while also waiting on expiry in the same state.
module sdram_init_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new delay or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_row_scan.sv
// Finds the lowest populated row at or above a scan pointer.
// It also reports whether that row is the last populated one.
// Purely combinational. Assumes scan_i ranges from 0 to ROWS.
module sdram_row_scan #(
    parameter int ROWS   = 8,
    parameter int IDX_W  = $clog2(ROWS),
    parameter int SCAN_W = $clog2(ROWS + 1)
) (
    input  logic [ROWS-1:0]   row_pop_i,
    input  logic [SCAN_W-1:0] scan_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  row_o,
    output logic              last_o
);

    // Priority search for the first candidate row and any later one.
    always_comb begin
        found_o = 1'b0;
        row_o   = '0;
        last_o  = 1'b1;
        for (int i = 0; i < ROWS; i++) begin
            if (row_pop_i[i] && (SCAN_W'(i) >= scan_i)) begin
                if (!found_o) begin
                    found_o = 1'b1;
                    row_o   = IDX_W'(i);
                end else begin
                    last_o  = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sdram_mode_addr.sv
// Forms the mode-register address word for one row.
// The lower half of the rows gets the base word for the chosen CAS latency.
// The upper half gets that word with the board-inverted bits flipped.
module sdram_mode_addr #(
    parameter int          ROWS      = 8,
    parameter int          IDX_W     = $clog2(ROWS),
    parameter int          ADDR_W    = 13,
    parameter logic [12:0] BASE_CL3  = 13'h01D0,
    parameter logic [12:0] BASE_CL2  = 13'h0150,
    parameter logic [12:0] FLIP_MASK = 13'h1FF8
) (
    input  logic              cas2_i,
    input  logic [IDX_W-1:0]  row_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HALF = ROWS / 2;

    logic [ADDR_W-1:0] base;

    // Pick the base word, then invert for the upper row half.
    always_comb begin
        base   = cas2_i ? ADDR_W'(BASE_CL2) : ADDR_W'(BASE_CL3);
        addr_o = (int'(row_i) >= HALF) ? (base ^ ADDR_W'(FLIP_MASK)) : base;
    end

endmodule

// File: rtl/sdram_init_seq.sv
// SDRAM power-up initialization sequencer (top).
// Steps: power wait, NOP, precharge-all, CBR_COUNT refreshes, mode-register set, normal.
// Each command is issued to every populated row on consecutive cycles, then the step's wait runs.
// Assumes row_pop_i and cas2_i stay stable while a sequence is running, and every wait is >= 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ROWS         = 8,
    parameter int ADDR_W       = 13,
    parameter int PWR_CYC      = 200,
    parameter int NOP_WAIT_CYC = 200,
    parameter int TRP_CYC      = 3,
    parameter int TRC_CYC      = 3,
    parameter int MRS_WAIT_CYC = 2,
    parameter int CBR_COUNT    = 8,
    localparam int IDX_W       = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cas2_i,
    input  logic [ROWS-1:0]   row_pop_i,
    output logic [2:0]        cmd_o,
    output logic              cmd_vld_o,
    output logic [IDX_W-1:0]  cs_idx_o,
    output logic [ADDR_W-1:0] mode_addr_o,
    output logic              refresh_en_o,
    output logic              done_o
);

    localparam int SCAN_W  = $clog2(ROWS + 1);
    localparam int MAX_A   = (PWR_CYC > NOP_WAIT_CYC) ? PWR_CYC : NOP_WAIT_CYC;
    localparam int MAX_B   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
    localparam int MAX_C   = (MAX_B > MRS_WAIT_CYC) ? MAX_B : MRS_WAIT_CYC;
    localparam int MAX_WT  = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W   = $clog2(MAX_WT + 1);
    localparam int CBR_W   = $clog2(CBR_COUNT + 1);

    seq_state_e        state_q, state_d;
    logic [SCAN_W-1:0] scan_q, scan_d;
    logic [CBR_W-1:0]  cbr_q, cbr_d;
    logic              tmr_ld;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              found, last;
    logic [IDX_W-1:0]  row;
    logic [ADDR_W-1:0] row_addr;
    logic              issuing;
    seq_state_e        iss_next;
    logic [CNT_W-1:0]  iss_len;

    sdram_init_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_ld),
        .load_val_i (tmr_val),
        .expired_o  (tmr_exp)
    );

    sdram_row_scan #(.ROWS(ROWS), .IDX_W(IDX_W), .SCAN_W(SCAN_W)) u_scan (
        .row_pop_i (row_pop_i),
        .scan_i    (scan_q),
        .found_o   (found),
        .row_o     (row),
        .last_o    (last)
    );

    sdram_mode_addr #(.ROWS(ROWS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_maddr (
        .cas2_i (cas2_i),
        .row_i  (row),
        .addr_o (row_addr)
    );

    // Next-state logic: start handling, waits, and the per-row issue walk.
    always_comb begin
        state_d  = state_q;
        scan_d   = scan_q;
        cbr_d    = cbr_q;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        issuing  = 1'b0;
        iss_next = state_q;
        iss_len  = '0;
        case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_PWR;
                    tmr_ld  = 1'b1;
                    tmr_val = CNT_W'(PWR_CYC - 1);
                end
            end
            ST_PWR:    if (tmr_exp) state_d = ST_NOP_ISS;
            ST_NOP_ISS: begin
                issuing  = 1'b1;
                iss_next = ST_NOP_WT;
                iss_len  = CNT_W'(NOP_WAIT_CYC - 1);
            end
            ST_NOP_WT: if (tmr_exp) state_d = ST_PRE_ISS;
            ST_PRE_ISS: begin
                issuing  = 1'b1;
                iss_next = ST_PRE_WT;
                iss_len  = CNT_W'(TRP_CYC - 1);
            end
            ST_PRE_WT: if (tmr_exp) state_d = ST_CBR_ISS;
            ST_CBR_ISS: begin
                issuing  = 1'b1;
                iss_next = ST_CBR_WT;
                iss_len  = CNT_W'(TRC_CYC - 1);
            end
            ST_CBR_WT: begin
                if (tmr_exp) begin
                    if (cbr_q == CBR_W'(CBR_COUNT - 1)) begin
                        cbr_d   = '0;
                        state_d = ST_MRS_ISS;
                    end else begin
                        cbr_d   = cbr_q + 1'b1;
                        state_d = ST_CBR_ISS;
                    end
                end
            end
            ST_MRS_ISS: begin
                issuing  = 1'b1;
                iss_next = ST_MRS_WT;
                iss_len  = CNT_W'(MRS_WAIT_CYC - 1);
            end
            ST_MRS_WT: if (tmr_exp) state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase

        if (issuing) begin
            if (!found || last) begin
                state_d = iss_next;
                scan_d  = '0;
                tmr_ld  = 1'b1;
                tmr_val = iss_len;
            end else begin
                scan_d  = SCAN_W'(row) + 1'b1;
            end
        end
    end

    // State, scan pointer and refresh counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scan_q  <= '0;
            cbr_q   <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= scan_d;
            cbr_q   <= cbr_d;
        end
    end

    // Command mode held for the whole step, including its wait.
    always_comb begin
        case (state_q)
            ST_NOP_ISS, ST_NOP_WT: cmd_o = SD_CMD_NOP;
            ST_PRE_ISS, ST_PRE_WT: cmd_o = SD_CMD_PREALL;
            ST_CBR_ISS, ST_CBR_WT: cmd_o = SD_CMD_CBR;
            ST_MRS_ISS, ST_MRS_WT: cmd_o = SD_CMD_MRS;
            default:               cmd_o = SD_CMD_NORMAL;
        endcase
    end

    // Issue strobe, row select and mode address for the current issue cycle.
    always_comb begin
        cmd_vld_o   = issuing && found;
        cs_idx_o    = cmd_vld_o ? row : '0;
        mode_addr_o = (cmd_vld_o && state_q == ST_MRS_ISS) ? row_addr : '0;
    end

    assign done_o       = (state_q == ST_DONE);
    assign refresh_en_o = (state_q == ST_DONE);

endmodule

// File: rtl/sdram_init_seq_chk.sv
// Cycle-by-cycle checker for the initialization sequencer, bound to the top module.
// Assumes row_pop_i is stable while issues are in flight.
module sdram_init_seq_chk #(
    parameter int ROWS   = 8,
    parameter int ADDR_W = 13,
    parameter int IDX_W  = $clog2(ROWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ROWS-1:0]   row_pop_i,
    input logic [2:0]        cmd_o,
    input logic              cmd_vld_o,
    input logic [IDX_W-1:0]  cs_idx_o,
    input logic [ADDR_W-1:0] mode_addr_o,
    input logic              refresh_en_o,
    input logic              done_o
);

    AST_ISSUE_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (cmd_o inside {3'b001, 3'b010, 3'b011, 3'b100})); // R2

    AST_ISSUE_ROW_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> row_pop_i[cs_idx_o]); // R4

    AST_ISSUE_ROW_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_o && $past(cmd_vld_o)) |-> (cs_idx_o > $past(cs_idx_o))); // R4

    AST_ADDR_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld_o && cmd_o == 3'b011) |-> (mode_addr_o == '0)); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cmd_vld_o && cmd_o == 3'b000 && refresh_en_o)); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R9

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !done_o); // R9

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .row_pop_i    (row_pop_i),
    .cmd_o        (cmd_o),
    .cmd_vld_o    (cmd_vld_o),
    .cs_idx_o     (cs_idx_o),
    .mode_addr_o  (mode_addr_o),
    .refresh_en_o (refresh_en_o),
    .done_o       (done_o)
);

// File: tb/sdram_init_seq_bench.sv
// Sweeps populated masks and both CAS latencies and replays whole initialization sequences.
// Every logged issue is compared with an arithmetic model of order, row, address and timing.
module sdram_init_seq_bench;

    localparam int ROWS = 8;
    localparam int PWR  = 6;
    localparam int NOPW = 4;
    localparam int TRP  = 3;
    localparam int TRC  = 2;
    localparam int MRSW = 2;
    localparam int NSTEP = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cas2_i = 1'b0;
    logic [7:0]  row_pop_i = 8'h00;
    logic [2:0]  cmd_o;
    logic        cmd_vld_o;
    logic [2:0]  cs_idx_o;
    logic [12:0] mode_addr_o;
    logic        refresh_en_o;
    logic        done_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 1'b0;

    int ev_n = 0;
    int ev_cmd [0:127];
    int ev_cs  [0:127];
    int ev_addr[0:127];
    int ev_cyc [0:127];

    sdram_init_seq #(
        .ROWS(ROWS), .ADDR_W(13), .PWR_CYC(PWR), .NOP_WAIT_CYC(NOPW),
        .TRP_CYC(TRP), .TRC_CYC(TRC), .MRS_WAIT_CYC(MRSW), .CBR_COUNT(8)
    ) u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cas2_i(cas2_i),
        .row_pop_i(row_pop_i), .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o),
        .cs_idx_o(cs_idx_o), .mode_addr_o(mode_addr_o),
        .refresh_en_o(refresh_en_o), .done_o(done_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log every issue strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmd_vld_o && ev_n < 128) begin
            ev_cmd[ev_n]  = int'(cmd_o);
            ev_cs[ev_n]   = int'(cs_idx_o);
            ev_addr[ev_n] = int'(mode_addr_o);
            ev_cyc[ev_n]  = cyc;
            ev_n = ev_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int step_cmd(input int s);
        if (s == 0) return 1;
        if (s == 1) return 2;
        if (s <= 9) return 4;
        return 3;
    endfunction

    function automatic int step_wait(input int s);
        if (s == 0) return NOPW;
        if (s == 1) return TRP;
        if (s <= 9) return TRC;
        return MRSW;
    endfunction

    function automatic int exp_addr(input int r, input bit c2);
        if (r < 4) return c2 ? 'h150 : 'h1D0;
        return c2 ? 'h1EA8 : 'h1E28;
    endfunction

    task automatic run_seq(input logic [7:0] mask, input bit c2, input bit busy_start);
        int s0;
        int pc;
        int idx;
        int t_exp;
        int done_cyc;
        int waited;
        row_pop_i = mask;
        cas2_i    = c2;
        ev_n      = 0;
        pc        = $countones(mask);
        @(negedge clk);
        start_i = 1'b1;
        @(posedge clk);
        #1 s0 = cyc;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0 && refresh_en_o == 1'b0, "R9 start clears done", int'(done_o), 0);
        if (busy_start) begin
            repeat (PWR + 2) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        done_cyc = cyc;
        check(done_o == 1'b1, "R8 done reached", int'(done_o), 1);
        check(ev_n == NSTEP * pc, "R4 issue count", ev_n, NSTEP * pc);
        if (pc == 0) begin
            check(ev_n == 0, "R11 empty mask issues nothing", ev_n, 0);
        end else if (ev_n == NSTEP * pc) begin
            idx   = 0;
            t_exp = s0 + PWR;
            check(ev_cyc[0] == t_exp, "R5 power wait", ev_cyc[0], t_exp);
            for (int s = 0; s < NSTEP; s++) begin
                for (int r = 0; r < ROWS; r++) begin
                    if (mask[r]) begin
                        check(ev_cmd[idx] == step_cmd(s), "R3 step order", ev_cmd[idx], step_cmd(s));
                        check(ev_cs[idx] == r, "R4 row select", ev_cs[idx], r);
                        if (step_cmd(s) == 3)
                            check(ev_addr[idx] == exp_addr(r, c2), "R7 mode address", ev_addr[idx], exp_addr(r, c2));
                        else
                            check(ev_addr[idx] == 0, "R7 address idle", ev_addr[idx], 0);
                        check(ev_cyc[idx] == t_exp, (busy_start ? "R10 timing under busy start" : "R6 issue timing"), ev_cyc[idx], t_exp);
                        idx++;
                        t_exp++;
                    end
                end
                t_exp = t_exp - 1 + step_wait(s) + 1;
            end
            check(done_cyc == ev_cyc[ev_n - 1] + MRSW + 1, "R8 done timing", done_cyc, ev_cyc[ev_n - 1] + MRSW + 1);
        end
        repeat (5) @(negedge clk);
        check(done_o && refresh_en_o && cmd_o == 3'b000 && !cmd_vld_o, "R9 done holds", int'({done_o, refresh_en_o}), 3);
        check(ev_n == NSTEP * pc, "R8 no issue after done", ev_n, NSTEP * pc);
    endtask

    initial begin
        logic [7:0] masks [0:8];
        masks[0] = 8'h01; masks[1] = 8'hFF; masks[2] = 8'hA5;
        masks[3] = 8'h80; masks[4] = 8'h18; masks[5] = 8'h0F;
        masks[6] = 8'hF0; masks[7] = 8'h00; masks[8] = 8'h42;
        repeat (3) @(negedge clk);
        check(!cmd_vld_o && !done_o && !refresh_en_o && cmd_o == 3'b000 && mode_addr_o == 0,
              "R1 reset state", int'({cmd_vld_o, done_o, refresh_en_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cmd_vld_o && !done_o && !refresh_en_o && cmd_o == 3'b000,
              "R1 after reset", int'({cmd_vld_o, done_o, refresh_en_o}), 0);
        check(cmd_o == 3'b000, "R2 normal encoding when idle", int'(cmd_o), 0);
        for (int m = 0; m < 9; m++) begin
            for (int c = 0; c < 2; c++) begin
                run_seq(masks[m], c[0], (m == 2 || m == 8));
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule